// File: doc/BRIEF.md
# Half-Duplex Two-Wire Debug Link Master

This block connects a host to the debug port of a small 8-bit microcontroller. The link has three wires. A serial clock that the master generates. One data line that both sides share. An active-low target reset. The shared data line is modelled as three signals: a driven value, an output enable and a sampled input. A pad or the surrounding logic combines them into one bidirectional pin. Bits move most significant first in both directions. The master changes its outgoing bit only at the falling edge of the link clock, and it samples the target's bit at the falling edge as well.

The host starts one of four operations with a single-cycle `cmd_start` strobe, while `busy` is low:

- **Enter debug:** holds reset low, gives two clock pulses, then releases reset.
- **Exit debug:** holds reset low for one half period, with no clock, then releases it.
- **Write:** sends `cmd_len` bytes.
- **Write-then-read:** sends `cmd_len` bytes, turns the line around and takes exactly one reply byte.

Outgoing bytes are pulled one at a time over a valid/ready interface. The reply appears on `rx_data` with a one-cycle `rx_valid`.

The state machine has these states:

| State | Role |
|---|---|
| IDLE | No command in progress |
| EN_LO, EN_HI, EN_REL | Enter sequence: clock low, clock high, reset release phase |
| EX_LO | Exit sequence |
| FETCH | Waits for the next outgoing byte |
| SEND_LO, SEND_HI | Low and high phase of each sent bit |
| TURN | Line turnaround before the reply |
| RECV_LO, RECV_HI | Low and high phase of each received bit |

The transitions are:

- **IDLE:** goes to EN_LO (enter), EX_LO (exit) or FETCH (write with bytes). A write-then-read with zero bytes goes to TURN. A write with zero bytes stays in IDLE.
- **EN_LO → EN_HI → EN_LO → EN_HI → EN_REL → IDLE.**
- **EX_LO → IDLE.**
- **FETCH → SEND_LO** when a byte is accepted.
- **SEND_LO ↔ SEND_HI** for each bit. After the eighth bit, SEND_HI goes to FETCH if more bytes remain. On the last byte it goes to TURN for a write-then-read, or to IDLE for a write.
- **TURN → RECV_LO.**
- **RECV_LO ↔ RECV_HI** for eight bits, then to IDLE.

Every state except IDLE and FETCH ends when the half-period divider expires.

Top module: `dbg2w_master`

## Requirements
- R1: After reset `busy`, `link_clk`, `link_oe` and `rx_valid` are low and `link_rst_n` is high.
- R2: A `cmd_start` is accepted only while `busy` is low. A strobe raised while `busy` is high has no effect: it causes no clock pulses, no byte requests and no change in state.
- R3: `cmd_op` encodes 2'b00 enter debug, 2'b01 exit debug, 2'b10 write, 2'b11 write-then-read.
- R4: Enter debug drives `link_rst_n` low for exactly 5 half periods. During that time it produces exactly two rising edges of `link_clk`. It then leaves `link_rst_n` high.
- R5: Exit debug drives `link_rst_n` low for exactly one half period, with no `link_clk` edge, then returns it high.
- R6: A write requests `cmd_len` bytes through `tx_valid`/`tx_ready`. It sends each byte as 8 clock pulses, MSB first, with `link_oe` high. Data holds while `link_clk` is high. A write returns no reply.
- R7: A write-then-read sends its bytes and then releases `link_oe`. It gives 8 more pulses, samples `link_din` at each falling edge (MSB first) and presents the byte on `rx_data` with a single-cycle `rx_valid`.
- R8: A byte count of zero makes a write-then-read skip sending and receive its single reply (8 pulses, no byte request). A write with zero bytes produces no pulses and leaves `busy` low.
- R9: `link_dout` is 0 whenever `link_oe` is low.
- R10: Every high phase of `link_clk` lasts exactly max(`half_period`,1) system clocks. Every low phase lasts at least that long. `half_period` must be held while `busy` is high.
- R11: While `busy` is low, `link_clk` and `link_oe` are low.
- R12: While the master waits for an outgoing byte (`tx_ready` high), `link_clk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | DIV_W | Link clock half period in system clocks (0 acts as 1) |
| cmd_start | input | 1 | Command strobe, taken while busy is low |
| cmd_op | input | 2 | Operation code (see R3) |
| cmd_len | input | CNT_W | Number of bytes to send |
| busy | output | 1 | Command in progress |
| tx_data | input | 8 | Outgoing byte |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Master takes tx_data this cycle if tx_valid |
| rx_data | output | 8 | Received reply byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| link_clk | output | 1 | Debug link clock |
| link_dout | output | 1 | Value driven on the data line |
| link_oe | output | 1 | Data line output enable |
| link_din | input | 1 | Sampled data line |
| link_rst_n | output | 1 | Active-low target reset |

## Verification
Several rules hold on every cycle and are checked as properties:

- a zero placeholder on the data output whenever the line is released;
- a quiet link while idle;
- a single-cycle reply strobe;
- no clock while a byte is awaited;
- no driving of the line while the target is in reset;
- the exact length of every clock high phase.

Other behaviour can only be shown by the bench's scenarios. These are:

- the bit order and byte content on the line;
- the two pulses inside the enter sequence;
- the reset width of the enter and exit sequences;
- the reply assembled from the pins;
- the zero-length commands;
- a command that is ignored while busy.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

    typedef enum logic [1:0] {
        OP_ENTER = 2'b00,
        OP_EXIT  = 2'b01,
        OP_WRITE = 2'b10,
        OP_WRRD  = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_EN_LO,
        S_EN_HI,
        S_EN_REL,
        S_EX_LO,
        S_FETCH,
        S_SEND_LO,
        S_SEND_HI,
        S_TURN,
        S_RECV_LO,
        S_RECV_HI
    } state_e;

endpackage

// File: rtl/dbg2w_tick.sv
// Half-period timer: pulses tick on the last cycle of each phase.
module dbg2w_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = (half_period == '0) ? DIV_W'(1) : half_period;
        tick = en && (cnt_q >= lim - DIV_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/dbg2w_shifter.sv
// MSB-first shift register shared by transmit and receive.
module dbg2w_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end
endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master
    import dbg2w_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_period,
    input  logic             cmd_start,
    input  logic [1:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_len,
    output logic             busy,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             link_clk,
    output logic             link_dout,
    output logic             link_oe,
    input  logic             link_din,
    output logic             link_rst_n
);
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    state_e           state, state_d;
    op_e              op_q;
    logic [CNT_W-1:0] remain_q;
    logic [BIT_W-1:0] bit_q;
    logic             pulse_q;
    logic             rst_lvl_q;
    logic             rx_valid_q;
    logic             tick;
    logic             tick_en;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_sin;
    logic [7:0]       sh_q;
    logic             accept;

    dbg2w_tick #(.DIV_W(DIV_W)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (tick_en),
        .half_period (half_period),
        .tick        (tick)
    );

    dbg2w_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (tx_data),
        .shift    (sh_shift),
        .sin      (sh_sin),
        .q        (sh_q)
    );

    assign accept = (state == S_IDLE) && cmd_start;

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_start) begin
                    unique case (op_e'(cmd_op))
                        OP_ENTER: state_d = S_EN_LO;
                        OP_EXIT:  state_d = S_EX_LO;
                        OP_WRITE: state_d = (cmd_len == '0) ? S_IDLE : S_FETCH;
                        OP_WRRD:  state_d = (cmd_len == '0) ? S_TURN : S_FETCH;
                    endcase
                end
            end
            S_EN_LO:  if (tick) state_d = S_EN_HI;
            S_EN_HI:  if (tick) state_d = pulse_q ? S_EN_REL : S_EN_LO;
            S_EN_REL: if (tick) state_d = S_IDLE;
            S_EX_LO:  if (tick) state_d = S_IDLE;
            S_FETCH:  if (tx_valid) state_d = S_SEND_LO;
            S_SEND_LO: if (tick) state_d = S_SEND_HI;
            S_SEND_HI: begin
                if (tick) begin
                    if (bit_q != LAST_BIT) begin
                        state_d = S_SEND_LO;
                    end else if (remain_q != CNT_W'(1)) begin
                        state_d = S_FETCH;
                    end else begin
                        state_d = (op_q == OP_WRRD) ? S_TURN : S_IDLE;
                    end
                end
            end
            S_TURN:    if (tick) state_d = S_RECV_LO;
            S_RECV_LO: if (tick) state_d = S_RECV_HI;
            S_RECV_HI: if (tick) state_d = (bit_q == LAST_BIT) ? S_IDLE : S_RECV_LO;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            op_q       <= OP_ENTER;
            remain_q   <= '0;
            bit_q      <= '0;
            pulse_q    <= 1'b0;
            rst_lvl_q  <= 1'b1;
            rx_valid_q <= 1'b0;
        end else begin
            state      <= state_d;
            rx_valid_q <= (state == S_RECV_HI) && tick && (bit_q == LAST_BIT);
            if (accept) begin
                op_q     <= op_e'(cmd_op);
                remain_q <= cmd_len;
                pulse_q  <= 1'b0;
                bit_q    <= '0;
                if (op_e'(cmd_op) == OP_ENTER || op_e'(cmd_op) == OP_EXIT) begin
                    rst_lvl_q <= 1'b0;
                end
            end
            if ((state == S_EN_REL || state == S_EX_LO) && tick) begin
                rst_lvl_q <= 1'b1;
            end
            if (state == S_EN_HI && tick) begin
                pulse_q <= 1'b1;
            end
            if (state == S_FETCH || state == S_TURN) begin
                bit_q <= '0;
            end else if ((state == S_SEND_HI || state == S_RECV_HI) && tick) begin
                bit_q <= bit_q + BIT_W'(1);
            end
            if (state == S_SEND_HI && tick && bit_q == LAST_BIT) begin
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        busy       = (state != S_IDLE);
        tick_en    = (state != S_IDLE) && (state != S_FETCH);
        link_clk   = (state == S_EN_HI) || (state == S_SEND_HI) || (state == S_RECV_HI);
        link_oe    = (state == S_FETCH) || (state == S_SEND_LO) || (state == S_SEND_HI);
        link_dout  = link_oe & sh_q[BYTE_W-1];
        link_rst_n = rst_lvl_q;
        tx_ready   = (state == S_FETCH);
        sh_load    = (state == S_FETCH) && tx_valid;
        sh_shift   = ((state == S_SEND_HI) || (state == S_RECV_HI)) && tick;
        sh_sin     = (state == S_RECV_HI) ? link_din : 1'b0;
        rx_data    = sh_q;
        rx_valid   = rx_valid_q;
    end
endmodule

// File: rtl/dbg2w_master_chk.sv
module dbg2w_master_chk #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] half_period,
    input logic             busy,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             link_clk,
    input logic             link_dout,
    input logic             link_oe,
    input logic             link_rst_n
);
    logic             prev_clk;
    logic [DIV_W:0]   run_q;
    logic [DIV_W:0]   lim_w;

    assign lim_w = (half_period == '0) ? (DIV_W+1)'(1) : {1'b0, half_period};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_clk <= 1'b0;
            run_q    <= '0;
        end else begin
            prev_clk <= link_clk;
            if (link_clk != prev_clk) begin
                run_q <= (DIV_W+1)'(1);
            end else if (run_q != '1) begin
                run_q <= run_q + (DIV_W+1)'(1);
            end
        end
    end

    assert_dout_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_oe |-> !link_dout);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!link_clk && !link_oe));

    assert_rx_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_stall_clk_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !link_clk);

    assert_drive_after_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        link_oe |-> link_rst_n);

    assert_high_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_clk && !link_clk) |-> (run_q == lim_w));
endmodule

bind dbg2w_master dbg2w_master_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_period (half_period),
    .busy        (busy),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .link_clk    (link_clk),
    .link_dout   (link_dout),
    .link_oe     (link_oe),
    .link_rst_n  (link_rst_n)
);

// File: tb/sim_dbg2w_master.sv
`timescale 1ns/1ps
module sim_dbg2w_master;
    localparam int DIV_W = 8;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] half_period = 8'd3;
    logic             cmd_start = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic [CNT_W-1:0] cmd_len = '0;
    logic             busy;
    logic [7:0]       tx_data;
    logic             tx_valid;
    logic             tx_ready;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic             link_clk, link_dout, link_oe, link_rst_n;
    logic             link_din = 1'b0;

    always #2 clk = ~clk;

    dbg2w_master #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .half_period(half_period),
        .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_len(cmd_len), .busy(busy),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .link_clk(link_clk), .link_dout(link_dout), .link_oe(link_oe),
        .link_din(link_din), .link_rst_n(link_rst_n)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // byte source ring
    logic [7:0] tx_mem [16];
    logic [3:0] wr_idx = '0;
    logic [3:0] feed_idx = '0;
    logic       stall = 1'b0;
    int         hs_count = 0;
    assign tx_data  = tx_mem[feed_idx];
    assign tx_valid = !stall && (feed_idx != wr_idx);
    always @(posedge clk) begin
        if (tx_ready && tx_valid) begin
            feed_idx <= feed_idx + 4'd1;
            hs_count <= hs_count + 1;
        end
    end

    // scoreboard queues
    logic [7:0] exp_q [$];
    logic [7:0] rx_q [$];
    logic [7:0] tgt_byte = '0;
    int         tgt_idx = 0;
    int         exp_lim = 3;

    int rises = 0, rises_rst_low = 0, rx_count = 0;
    int hi_bad = 0, lo_bad = 0, dz_bad = 0;
    int hrun = 0, lrun = 0, rlow = 0, last_rst_low = 0;
    int nbits = 0;
    logic [7:0] mon_sh = '0;
    logic p_clk = 1'b0, p_rst = 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!link_oe && link_dout) dz_bad++;
            if (link_clk && !p_clk) begin
                rises++;
                if (!link_rst_n) rises_rst_low++;
                if (lrun < exp_lim) lo_bad++;
                if (link_oe) begin
                    mon_sh = {mon_sh[6:0], link_dout};
                    nbits++;
                    if (nbits == 8) begin
                        nbits = 0;
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R6 unexpected byte", mon_sh, 0);
                        end else begin
                            logic [7:0] e;
                            e = exp_q.pop_front();
                            chk(mon_sh == e, "R6 sent byte", mon_sh, e);
                        end
                    end
                end else begin
                    link_din = tgt_byte[7 - (tgt_idx % 8)];
                    tgt_idx++;
                end
            end
            if (!link_clk && p_clk) begin
                if (hrun != exp_lim) hi_bad++;
            end
            if (link_clk) begin
                hrun = (p_clk) ? hrun + 1 : 1;
            end else begin
                lrun = (!p_clk) ? lrun + 1 : 1;
            end
            if (!link_rst_n) begin
                rlow++;
            end else if (!p_rst) begin
                last_rst_low = rlow;
                rlow = 0;
            end
            if (rx_valid) begin
                rx_count++;
                if (rx_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected reply", rx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = rx_q.pop_front();
                    chk(rx_data == e, "R7 reply byte", rx_data, e);
                end
            end
            p_clk = link_clk;
            p_rst = link_rst_n;
        end
    end

    task automatic clear_counts();
        rises = 0; rises_rst_low = 0; rx_count = 0; hs_count = 0;
        tgt_idx = 0; nbits = 0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_mem[wr_idx] = b;
        wr_idx = wr_idx + 4'd1;
        exp_q.push_back(b);
    endtask

    task automatic issue(input logic [1:0] op, input int len);
        @(negedge clk);
        cmd_op = op; cmd_len = CNT_W'(len); cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [1:0] op, input int len);
        issue(op, len);
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, link_clk, link_oe, rx_valid, link_rst_n} == 5'b00001, "R1 reset state",
            {busy, link_clk, link_oe, rx_valid, link_rst_n}, 1);

        // R3 R4 enter debug (op 00)
        clear_counts();
        do_cmd(2'b00, 0);
        chk(rises_rst_low == 2, "R4 pulses in reset", rises_rst_low, 2);
        chk(rises == 2, "R4 total pulses", rises, 2);
        chk(last_rst_low == 15, "R4 reset width", last_rst_low, 15);
        chk(link_rst_n == 1'b1, "R4 reset released", link_rst_n, 1);

        // R5 exit debug (op 01)
        clear_counts();
        do_cmd(2'b01, 0);
        chk(rises == 0, "R5 no pulses", rises, 0);
        chk(last_rst_low == 3, "R5 reset width", last_rst_low, 3);

        // R6 write of three bytes (op 10)
        clear_counts();
        push_tx(8'h96); push_tx(8'h01); push_tx(8'hFE);
        do_cmd(2'b10, 3);
        chk(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);
        chk(hs_count == 3, "R6 byte requests", hs_count, 3);
        chk(rises == 24, "R6 pulse count", rises, 24);
        chk(rx_count == 0, "R6 no reply", rx_count, 0);
        chk(!link_clk && !link_oe, "R11 idle after write", {link_clk, link_oe}, 0);

        // R7 write-then-read (op 11)
        clear_counts();
        tgt_byte = 8'hA5;
        push_tx(8'h5A); push_tx(8'hC3);
        rx_q.push_back(8'hA5);
        do_cmd(2'b11, 2);
        chk(rises == 24, "R7 pulse count", rises, 24);
        chk(rx_count == 1, "R7 reply count", rx_count, 1);
        chk(rx_q.size() == 0, "R7 reply consumed", rx_q.size(), 0);

        // R8 zero-length write-then-read
        clear_counts();
        tgt_byte = 8'h3C;
        rx_q.push_back(8'h3C);
        do_cmd(2'b11, 0);
        chk(rises == 8, "R8 receive only pulses", rises, 8);
        chk(hs_count == 0, "R8 no byte request", hs_count, 0);
        chk(rx_count == 1, "R8 reply count", rx_count, 1);

        // R8 zero-length write
        clear_counts();
        do_cmd(2'b10, 0);
        chk(rises == 0 && !busy, "R8 empty write", rises, 0);

        // R10 half period of zero acts as one
        half_period = 8'd0; exp_lim = 1;
        clear_counts();
        push_tx(8'h81);
        do_cmd(2'b10, 1);
        tgt_byte = 8'h99;
        push_tx(8'h7E);
        rx_q.push_back(8'h99);
        do_cmd(2'b11, 1);
        chk(rises == 24, "R10 fast pulse count", rises, 24);
        chk(rx_count == 1 && rx_q.size() == 0, "R10 fast reply", rx_count, 1);
        half_period = 8'd3; exp_lim = 3;

        // R12 byte stall keeps the clock low
        clear_counts();
        stall = 1'b1;
        push_tx(8'h42);
        issue(2'b10, 1);
        repeat (20) @(negedge clk);
        chk(rises == 0 && busy && tx_ready, "R12 stall", rises, 0);
        stall = 1'b0;
        wait_idle();
        chk(exp_q.size() == 0 && rises == 8, "R12 resumed byte", rises, 8);

        // R2 strobe during busy is ignored
        clear_counts();
        issue(2'b01, 0);
        cmd_op = 2'b10; cmd_len = 8'd2; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(hs_count == 0 && rises == 0 && !busy && !tx_ready, "R2 ignored command",
            hs_count + rises, 0);

        chk(hi_bad == 0, "R10 high phase width", hi_bad, 0);
        chk(lo_bad == 0, "R10 low phase width", lo_bad, 0);
        chk(dz_bad == 0, "R9 released data zero", dz_bad, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule